// File: doc/BRIEF.md
# Double-Buffered Timer-Driven PWM Channel

This block is one pulse-width output channel with its own free-running timer. A selectable prescaler divides the clock, and the timer counts prescaled steps from zero up to a programmed period value. The output pin goes high at the start of each period. It falls on the step where the timer reaches the active duty value. Software writes the duty into a buffer register. The buffer is copied into the active compare register only when the timer wraps, so the pulse width never changes partway through a period.

A mode input turns the channel into a single compare. In that mode the pin goes high, and a compare flag is set, on the step where the timer reaches the written value. The timer flag and the compare flag are sticky. Each flag reaches its interrupt output only when its own enable is set. A sleep input freezes the whole channel: the timer, the prescaler and the pin level. In idle, the channel keeps running only while both stop-in-idle controls are low.

The pin comes from a two-state machine, PIN_LOW and PIN_HIGH, with four named transitions. ROLL_SET goes from PIN_LOW to PIN_HIGH on a PWM wrap when the buffered duty is not zero. ROLL_ZERO goes from PIN_HIGH to PIN_LOW on a PWM wrap when the buffered duty is zero. DUTY_CLEAR goes from PIN_HIGH to PIN_LOW when the timer reaches the active duty. CMP_SET goes from PIN_LOW to PIN_HIGH on a compare-mode match. Every other case holds the current state.

Top module: `ocpwm_channel`

## Requirements
- R1: After reset, the pin is low and the timer is zero. Both flags, the duty buffer and the active duty are zero.
- R2: `prescale_sel` values 0, 1, 2 and 3 give one timer step every 1, 8, 64 and 256 clocks. The prescaler is held cleared while `tmr_en` is low, so the first step comes exactly one full ratio of clocks after enabling.
- R3: The timer counts 0, 1, …, `period`, then returns to 0 on the next step. One period is therefore (period+1) × ratio clocks.
- R4: On a wrap step in PWM mode (`cmp_mode`=0), the timer goes to 0, the buffered duty is copied to the active duty, the pin is set high (unless R6 applies), and the timer flag is set. All of this happens on the same step.
- R5: In PWM mode the pin falls on the step where the timer reaches the active duty D. The pin is therefore high for min(D, period+1) steps of each period.
- R6: An active duty of zero keeps the pin low for the whole period.
- R7: An active duty greater than `period` keeps the pin high for the whole period.
- R8: A write to the duty buffer has no effect on the pulse width of the current period. It takes effect from the next wrap.
- R9: With `cmp_mode`=1, the pin is driven high and the compare flag is set on the step where the timer reaches the buffered value. The compare flag never becomes set in PWM mode.
- R10: Each flag stays set until its clear pulse. A set on the same clock wins over the clear. `tmr_irq` and `cmp_irq` show each flag only while its enable is high.
- R11: While `sleep` is high, the timer, the prescaler and the pin hold their values. Counting resumes from the held state when `sleep` falls.
- R12: While `idle` is high, the channel runs only if `ch_stop_idle` and `tmr_stop_idle` are both low. If either is high, the channel holds as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable |
| prescale_sel | input | 2 | Prescale ratio select (1/8/64/256) |
| period | input | 16 | Terminal timer value |
| duty_wr_en | input | 1 | Write strobe for the duty buffer |
| duty_wr_data | input | 16 | Duty or compare value to buffer |
| cmp_mode | input | 1 | 1 = single compare, 0 = PWM |
| sleep | input | 1 | Freeze the whole channel |
| idle | input | 1 | Idle condition |
| ch_stop_idle | input | 1 | Channel stops while idle |
| tmr_stop_idle | input | 1 | Timer stops while idle |
| tmr_ie | input | 1 | Timer interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| tmr_if_clr | input | 1 | Clear pulse for the timer flag |
| cmp_if_clr | input | 1 | Clear pulse for the compare flag |
| pwm_pin | output | 1 | Channel output |
| tmr_irq | output | 1 | Timer flag qualified by its enable |
| cmp_irq | output | 1 | Compare flag qualified by its enable |
| tmr_count | output | 16 | Current timer value |

## Verification
The bench measures high time per period at the duty boundaries 0, period, period+1 and above period. A design that latches the duty at the wrong step, or that compares against the unclamped duty, shows a pulse that is one step off, or a glitch at zero. It rewrites the duty in mid-period and expects the old width for that period. A design without double-buffering shortens or stretches the pulse at once. It also checks that sleep and either idle stop bit freeze the timer and the pin, and that the first step after enabling comes exactly one ratio of clocks later. A design that keeps a stale prescaler count shows that step early.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV8   = 2'd1,
        PS_DIV64  = 2'd2,
        PS_DIV256 = 2'd3
    } presc_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    // Terminal count of the prescaler: ratio minus one.
    function automatic logic [7:0] presc_limit(input presc_e sel);
        logic [7:0] lim;
        unique case (sel)
            PS_DIV1:   lim = 8'd0;
            PS_DIV8:   lim = 8'd7;
            PS_DIV64:  lim = 8'd63;
            PS_DIV256: lim = 8'd255;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/ocpwm_prescaler.sv
module ocpwm_prescaler
    import ocpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(presc_limit(presc_e'(sel)));
    assign tick  = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q >= limit) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ocpwm_timebase.sv
module ocpwm_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign count      = cnt_q;
    assign wrap       = tick && (cnt_q == period);
    assign count_next = wrap ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= count_next;
    end
endmodule

// File: rtl/ocpwm_out_fsm.sv
module ocpwm_out_fsm
    import ocpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] count_next,
    input  logic         cmp_mode,
    input  logic [W-1:0] duty_buf,
    input  logic         tmr_if_clr,
    input  logic         cmp_if_clr,
    output logic         pin,
    output logic         tmr_flag,
    output logic         cmp_flag
);
    pin_state_e   state_q, state_d;
    logic [W-1:0] active_q;
    logic         tmr_flag_q, cmp_flag_q;
    logic         pwm_wrap, pwm_clear, cmp_hit;

    assign pwm_wrap  = wrap && !cmp_mode;
    assign pwm_clear = tick && !cmp_mode && !wrap && (count_next == active_q);
    assign cmp_hit   = tick && cmp_mode && (count_next == duty_buf);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW: begin
                if (pwm_wrap && (duty_buf != '0)) state_d = PIN_HIGH;  // ROLL_SET
                else if (cmp_hit)                 state_d = PIN_HIGH;  // CMP_SET
            end
            PIN_HIGH: begin
                if (pwm_wrap && (duty_buf == '0)) state_d = PIN_LOW;   // ROLL_ZERO
                else if (pwm_clear)               state_d = PIN_LOW;   // DUTY_CLEAR
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PIN_LOW;
            active_q   <= '0;
            tmr_flag_q <= 1'b0;
            cmp_flag_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wrap) active_q <= duty_buf;
            if (wrap)            tmr_flag_q <= 1'b1;
            else if (tmr_if_clr) tmr_flag_q <= 1'b0;
            if (cmp_hit)         cmp_flag_q <= 1'b1;
            else if (cmp_if_clr) cmp_flag_q <= 1'b0;
        end
    end

    always_comb begin
        pin      = (state_q == PIN_HIGH);
        tmr_flag = tmr_flag_q;
        cmp_flag = cmp_flag_q;
    end
endmodule

// File: rtl/ocpwm_channel.sv
module ocpwm_channel
    import ocpwm_pkg::*;
#(
    parameter int W       = 16,
    parameter int PRESC_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmr_en,
    input  logic [1:0]   prescale_sel,
    input  logic [W-1:0] period,
    input  logic         duty_wr_en,
    input  logic [W-1:0] duty_wr_data,
    input  logic         cmp_mode,
    input  logic         sleep,
    input  logic         idle,
    input  logic         ch_stop_idle,
    input  logic         tmr_stop_idle,
    input  logic         tmr_ie,
    input  logic         cmp_ie,
    input  logic         tmr_if_clr,
    input  logic         cmp_if_clr,
    output logic         pwm_pin,
    output logic         tmr_irq,
    output logic         cmp_irq,
    output logic [W-1:0] tmr_count
);
    logic         run, tick, wrap;
    logic [W-1:0] count_next;
    logic [W-1:0] duty_buf;
    logic         tmr_flag, cmp_flag;

    assign run = tmr_en && !sleep && !(idle && (ch_stop_idle || tmr_stop_idle));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          duty_buf <= '0;
        else if (duty_wr_en) duty_buf <= duty_wr_data;
    end

    ocpwm_prescaler #(.CNT_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .enable(tmr_en), .run(run),
        .sel(prescale_sel), .tick(tick)
    );

    ocpwm_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
        .count(tmr_count), .count_next(count_next), .wrap(wrap)
    );

    ocpwm_out_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap),
        .count_next(count_next), .cmp_mode(cmp_mode), .duty_buf(duty_buf),
        .tmr_if_clr(tmr_if_clr), .cmp_if_clr(cmp_if_clr),
        .pin(pwm_pin), .tmr_flag(tmr_flag), .cmp_flag(cmp_flag)
    );

    assign tmr_irq = tmr_flag && tmr_ie;
    assign cmp_irq = cmp_flag && cmp_ie;
endmodule

// File: rtl/ocpwm_checks.sv
module ocpwm_checks #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic         wrap,
    input logic         cmp_mode,
    input logic [W-1:0] period,
    input logic [W-1:0] tmr_count,
    input logic [W-1:0] duty_buf,
    input logic         pwm_pin,
    input logic         tmr_flag,
    input logic         cmp_flag
);
    // R4: a wrap step returns the timer to zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tmr_count == period)) |=> (tmr_count == '0));

    // R4: a wrap step sets the timer flag
    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tmr_count == period)) |=> tmr_flag);

    // R4 / R6: in PWM mode the pin after a wrap follows the buffered duty
    a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tmr_count == period) && !cmp_mode) |=> (pwm_pin == ($past(duty_buf) != '0)));

    // R9: the compare flag never rises in PWM mode
    a_r9_no_cmp_flag_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_mode && !cmp_flag) |=> !cmp_flag);

    // R11 / R12: a halted channel holds timer and pin
    a_r11_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(tmr_count) && $stable(pwm_pin)));
endmodule

bind ocpwm_channel ocpwm_checks #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wrap(wrap),
    .cmp_mode(cmp_mode), .period(period), .tmr_count(tmr_count),
    .duty_buf(duty_buf), .pwm_pin(pwm_pin), .tmr_flag(tmr_flag),
    .cmp_flag(cmp_flag)
);

// File: tb/ocpwm_channel_tb.sv
module ocpwm_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic [1:0]  prescale_sel = 2'd0;
    logic [15:0] period = 16'd9;
    logic        duty_wr_en = 1'b0;
    logic [15:0] duty_wr_data = 16'd0;
    logic        cmp_mode = 1'b0;
    logic        sleep = 1'b0, idle = 1'b0;
    logic        ch_stop_idle = 1'b0, tmr_stop_idle = 1'b0;
    logic        tmr_ie = 1'b0, cmp_ie = 1'b0;
    logic        tmr_if_clr = 1'b0, cmp_if_clr = 1'b0;
    logic        pwm_pin, tmr_irq, cmp_irq;
    logic [15:0] tmr_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ocpwm_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .prescale_sel(prescale_sel),
        .period(period), .duty_wr_en(duty_wr_en), .duty_wr_data(duty_wr_data),
        .cmp_mode(cmp_mode), .sleep(sleep), .idle(idle),
        .ch_stop_idle(ch_stop_idle), .tmr_stop_idle(tmr_stop_idle),
        .tmr_ie(tmr_ie), .cmp_ie(cmp_ie), .tmr_if_clr(tmr_if_clr),
        .cmp_if_clr(cmp_if_clr), .pwm_pin(pwm_pin), .tmr_irq(tmr_irq),
        .cmp_irq(cmp_irq), .tmr_count(tmr_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tmr_en = 1'b0; prescale_sel = 2'd0; cmp_mode = 1'b0;
        sleep = 1'b0; idle = 1'b0; ch_stop_idle = 1'b0; tmr_stop_idle = 1'b0;
        tmr_ie = 1'b0; cmp_ie = 1'b0; duty_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Write at a negedge where the timer reads 1, well clear of a wrap.
    task automatic write_duty(input logic [15:0] v);
        do @(negedge clk); while (tmr_count != 16'd1);
        duty_wr_en = 1'b1; duty_wr_data = v;
        @(negedge clk);
        duty_wr_en = 1'b0;
    endtask

    // Count high samples over one full period (prescale 1) starting at timer 0.
    task automatic measure(output int high);
        high = 0;
        while (tmr_count != 16'd0) @(negedge clk);
        for (int i = 0; i <= int'(period); i++) begin
            if (pwm_pin) high++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(pwm_pin == 1'b0, "R1 pin", pwm_pin, 0);
        chk(tmr_count == 16'd0, "R1 timer", tmr_count, 0);
        tmr_ie = 1'b1; cmp_ie = 1'b1; #1;
        chk(tmr_irq == 1'b0, "R1 timer flag", tmr_irq, 0);
        chk(cmp_irq == 1'b0, "R1 compare flag", cmp_irq, 0);
    endtask

    task automatic t_duty(input logic [15:0] p, input logic [15:0] d, input string req);
        int h;
        int exp;
        do_reset();
        period = p; tmr_en = 1'b1;
        write_duty(d);
        measure(h);
        exp = (int'(d) > int'(p) + 1) ? int'(p) + 1 : int'(d);
        chk(h == exp, req, h, exp);
        measure(h);
        chk(h == exp, {req, " repeat"}, h, exp);
    endtask

    task automatic t_buffer();
        int h;
        do_reset();
        period = 16'd9; tmr_en = 1'b1;
        write_duty(16'd4);
        measure(h);
        while (tmr_count != 16'd0) @(negedge clk);
        h = 0;
        for (int i = 0; i <= 9; i++) begin
            if (pwm_pin) h++;
            if (i == 1) begin duty_wr_en = 1'b1; duty_wr_data = 16'd7; end
            if (i == 2) duty_wr_en = 1'b0;
            @(negedge clk);
        end
        chk(h == 4, "R8 mid-period write ignored", h, 4);
        measure(h);
        chk(h == 7, "R8 new duty after wrap", h, 7);
    endtask

    task automatic t_prescale(input logic [1:0] sel, input int ratio);
        int n;
        logic [15:0] prev;
        do_reset();
        period = 16'd100; prescale_sel = sel;
        @(negedge clk);
        tmr_en = 1'b1;
        prev = tmr_count; n = 0;
        do begin @(negedge clk); n++; end while (tmr_count == prev && n < 1000);
        chk(n == ratio, "R2 first step after enable", n, ratio);
        chk(tmr_count == prev + 16'd1, "R3 step size", tmr_count, prev + 16'd1);
        prev = tmr_count; n = 0;
        do begin @(negedge clk); n++; end while (tmr_count == prev && n < 1000);
        chk(n == ratio, "R2 steady step spacing", n, ratio);
    endtask

    task automatic t_wrap_flags();
        do_reset();
        period = 16'd5; tmr_en = 1'b1;
        do @(negedge clk); while (tmr_count != 16'd5);
        @(negedge clk);
        chk(tmr_count == 16'd0, "R3 wrap to zero", tmr_count, 0);
        tmr_ie = 1'b1; cmp_ie = 1'b1; #1;
        chk(tmr_irq == 1'b1, "R4 timer flag set at wrap", tmr_irq, 1);
        chk(cmp_irq == 1'b0, "R9 no compare flag in PWM mode", cmp_irq, 0);
        do @(negedge clk); while (tmr_count != 16'd2);
        chk(tmr_irq == 1'b1, "R10 flag sticky", tmr_irq, 1);
        tmr_if_clr = 1'b1;
        @(negedge clk);
        tmr_if_clr = 1'b0;
        chk(tmr_irq == 1'b0, "R10 flag cleared", tmr_irq, 0);
        do @(negedge clk); while (tmr_count != 16'd5);
        tmr_if_clr = 1'b1;
        @(negedge clk);
        tmr_if_clr = 1'b0;
        chk(tmr_irq == 1'b1, "R10 set wins over clear", tmr_irq, 1);
        tmr_ie = 1'b0; #1;
        chk(tmr_irq == 1'b0, "R10 enable gates output", tmr_irq, 0);
    endtask

    task automatic t_compare();
        do_reset();
        cmp_mode = 1'b1; cmp_ie = 1'b1; period = 16'd20;
        duty_wr_en = 1'b1; duty_wr_data = 16'd5;
        @(negedge clk);
        duty_wr_en = 1'b0; tmr_en = 1'b1;
        do @(negedge clk); while (tmr_count != 16'd4);
        chk(pwm_pin == 1'b0, "R9 pin low before match", pwm_pin, 0);
        @(negedge clk);
        chk(pwm_pin == 1'b1, "R9 pin high on match", pwm_pin, 1);
        chk(cmp_irq == 1'b1, "R9 compare flag on match", cmp_irq, 1);
    endtask

    task automatic t_sleep();
        bit held;
        do_reset();
        period = 16'd9; tmr_en = 1'b1;
        write_duty(16'd4);
        measure(held);
        do @(negedge clk); while (tmr_count != 16'd2);
        sleep = 1'b1;
        held = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tmr_count != 16'd2 || pwm_pin != 1'b1) held = 1'b0;
        end
        chk(held, "R11 sleep holds timer and pin", held, 1);
        sleep = 1'b0;
        @(negedge clk);
        chk(tmr_count == 16'd3, "R11 resume after sleep", tmr_count, 3);
    endtask

    task automatic t_idle();
        logic [15:0] t0;
        do_reset();
        period = 16'd200; tmr_en = 1'b1;
        @(negedge clk);
        idle = 1'b1;
        t0 = tmr_count;
        @(negedge clk);
        chk(tmr_count == t0 + 16'd1, "R12 idle with stop bits low runs", tmr_count, t0 + 16'd1);
        ch_stop_idle = 1'b1;
        t0 = tmr_count;
        repeat (5) @(negedge clk);
        chk(tmr_count == t0, "R12 channel stop bit halts", tmr_count, t0);
        ch_stop_idle = 1'b0; tmr_stop_idle = 1'b1;
        repeat (5) @(negedge clk);
        chk(tmr_count == t0, "R12 timer stop bit halts", tmr_count, t0);
        idle = 1'b0;
        @(negedge clk);
        chk(tmr_count == t0 + 16'd1, "R12 leaving idle resumes", tmr_count, t0 + 16'd1);
    endtask

    initial begin
        t_reset();
        t_duty(16'd9, 16'd4, "R5 duty 4 of period 9");
        t_duty(16'd9, 16'd0, "R6 zero duty stays low");
        t_duty(16'd9, 16'd9, "R5 duty equal to period");
        t_duty(16'd9, 16'd10, "R7 duty period+1 stays high");
        t_duty(16'd9, 16'd300, "R7 duty above period stays high");
        t_buffer();
        t_prescale(2'd0, 1);
        t_prescale(2'd1, 8);
        t_prescale(2'd2, 64);
        t_prescale(2'd3, 256);
        t_wrap_flags();
        t_compare();
        t_sleep();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule